// File: doc/BRIEF.md
# Burst Power Ramp Scaler

This block shapes the power envelope of a bursty transmit stream. Every incoming sample is first multiplied by a fine gain and then by a ramp factor. The ramp factor is read from a small table that software loads through a write port. When a burst opens, the block walks the table upward, one entry per valid sample, so the signal rises smoothly. While the burst stays open it holds the factor at full scale. When the burst closes it walks the same table back down in reverse order. Outside a burst the block emits zeros. This keeps on/off transitions free of the hard edges that would spread energy into neighbouring channels.

A burst-enable input acts as the synchronizing signal. The number of table entries that form a ramp is programmable. An optional interpolation mode places the mean of each pair of adjacent entries between them, which nearly doubles the ramp length without using more storage. Output samples follow input samples with one register of latency, and invalid input cycles advance nothing.

Top module: `burst_ramp_scaler`

## Requirements
- R1: A cycle with `coef_we` high stores `coef_wdata` into table entry `coef_addr` (64 entries of 16 bits). An entry value v means a factor of v/65536. The next ramp uses the new value.
- R2: `coef_count` gives the number N of table entries per ramp, from 1 to 64. A value of 0 acts as 1, and any value above 64 acts as 64.
- R3: Each output equals sat16(floor(floor(x*g/2^14)*f/2^16)). Here x is the signed input, g is the 15-bit unsigned `fine_gain` (g/16384 lies in [0,2)) and f is the ramp factor in effect.
- R4: `out_valid` is `in_valid` delayed by one clock, and `out_data` is updated only for valid samples. After reset both are 0.
- R5: The first valid sample with `burst_en` high while idle uses entry 0. Each later valid sample uses the next entry. Cycles without `in_valid` do not advance the ramp.
- R6: After the last ramp entry, the factor is held at 0xFFFF for as long as `burst_en` stays high.
- R7: The first valid sample with `burst_en` low after full power uses the last ramp entry. Later samples walk back to entry 0, after which the block is idle.
- R8: If `burst_en` drops during the ramp-up, the ramp-down starts from the entry used by the previous sample and walks back to entry 0.
- R9: With `interp_en` set, the ramp sequence is c0, (c0+c1)>>1, c1, …, (c[N-2]+c[N-1])>>1, c[N-1]. That is 2N-1 factors, and the ramp-down uses the reverse order.
- R10: While idle with `burst_en` low, every valid sample produces an output of 0.
- R11: `burst_en` rising during a ramp-down is ignored until the ramp-down has finished. The next valid sample with `burst_en` high then starts a fresh ramp at entry 0.
- R12: Results beyond the 16-bit signed range saturate to 32767 or -32768. A non-negative input never yields a negative output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| burst_en | input | 1 | Burst open (high) / closed (low) |
| fine_gain | input | 15 | Unsigned gain, value/16384 |
| coef_we | input | 1 | Ramp table write enable |
| coef_addr | input | 6 | Ramp table write address |
| coef_wdata | input | 16 | Ramp table write data, value/65536 |
| coef_count | input | 7 | Entries per ramp (clamped to 1..64) |
| interp_en | input | 1 | Insert averaged entries between stored ones |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Signed scaled sample |

## Verification
The hardest situations to reach are those where the burst-enable edge arrives somewhere other than at full power. One case is a burst that closes part-way through its ramp-up. The other is a burst that reopens while the ramp-down is still running. The stimulus handles both by counting valid samples exactly: it toggles `burst_en` after a chosen number of samples into each ramp, and it inserts idle cycles inside the ramp so that those gaps are shown not to advance the position. The bench predicts each factor from its own copy of the table contents. That includes the averaged entries in interpolated mode and the clamped lengths for counts of 0 and above 64.

// File: rtl/burst_ramp_scaler.sv
module burst_ramp_scaler #(
  parameter int DW = 16,
  parameter int GW = 15,
  parameter int CW = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 burst_en,
  input  logic [GW-1:0]        fine_gain,
  input  logic                 coef_we,
  input  logic [AW-1:0]        coef_addr,
  input  logic [CW-1:0]        coef_wdata,
  input  logic [NW-1:0]        coef_count,
  input  logic                 interp_en,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);

  localparam int SW  = AW + 2;
  localparam int MW  = DW + GW + 1;
  localparam int P1W = MW - (GW - 1);
  localparam int M2W = P1W + CW + 1;
  localparam int P2W = M2W - CW;

  typedef enum logic [1:0] {S_IDLE, S_UP, S_FULL, S_DOWN} st_t;

  st_t           state, nstate;
  logic [SW-1:0] step, nstep, idx, last;
  logic [NW-1:0] n_eff;
  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] tab, factor;
  logic [AW-1:0] base;
  logic [CW:0]   pair_sum;
  logic          odd, use_tab, use_max, going_down;

  always_ff @(posedge clk)
    if (coef_we) mem[coef_addr] <= coef_wdata;

  assign n_eff = (coef_count == '0) ? NW'(1) :
                 (coef_count > NW'(DEPTH)) ? NW'(DEPTH) : coef_count;
  assign last  = interp_en ? SW'({n_eff, 1'b0}) - SW'(2) : SW'(n_eff) - SW'(1);

  always_comb begin
    nstate = state;
    nstep = step;
    idx = '0;
    use_tab = 1'b0;
    use_max = 1'b0;
    going_down = 1'b0;
    case (state)
      S_IDLE:
        if (burst_en) begin
          use_tab = 1'b1;
          nstate = (last == '0) ? S_FULL : S_UP;
          nstep = SW'(1);
        end
      S_UP:
        if (burst_en) begin
          use_tab = 1'b1;
          idx = step;
          nstate = (step == last) ? S_FULL : S_UP;
          nstep = step + SW'(1);
        end else begin
          use_tab = 1'b1;
          idx = step - SW'(1);
          going_down = 1'b1;
        end
      S_FULL:
        if (burst_en) use_max = 1'b1;
        else begin
          use_tab = 1'b1;
          idx = last;
          going_down = 1'b1;
        end
      default: begin
        use_tab = 1'b1;
        idx = step;
        going_down = 1'b1;
      end
    endcase
    if (going_down) begin
      nstate = (idx == '0) ? S_IDLE : S_DOWN;
      nstep = idx - SW'(1);
    end
  end

  assign odd      = interp_en & idx[0];
  assign base     = interp_en ? AW'(idx >> 1) : AW'(idx);
  assign pair_sum = {1'b0, mem[base]} + {1'b0, mem[base + AW'(1)]};
  assign tab      = odd ? pair_sum[CW:1] : mem[base];
  assign factor   = use_max ? {CW{1'b1}} : (use_tab ? tab : '0);

  logic signed [MW-1:0]  prod1;
  logic signed [P1W-1:0] p1;
  logic signed [M2W-1:0] prod2;
  logic signed [P2W-1:0] p2;
  logic [P2W-DW:0]       hi;
  logic signed [DW-1:0]  satv;

  assign prod1 = MW'(in_data) * MW'($signed({1'b0, fine_gain}));
  assign p1    = P1W'(prod1 >>> (GW - 1));
  assign prod2 = M2W'(p1) * M2W'($signed({1'b0, factor}));
  assign p2    = P2W'(prod2 >>> CW);
  assign hi    = p2[P2W-1:DW-1];
  assign satv  = (&hi || ~|hi) ? p2[DW-1:0] :
                 (p2[P2W-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data <= '0;
      state <= S_IDLE;
      step <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= satv;
        state <= nstate;
        step <= nstep;
      end
    end

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r5_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(step) && $stable(state) && $stable(out_data)));
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FULL && !(in_valid && !burst_en)) |=> state == S_FULL);
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && state == S_IDLE && !burst_en) |=> out_data == '0);
  a_r11_down_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DOWN) |=> (state == S_DOWN || state == S_IDLE));
  a_r12_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_data[DW-1]) |=> !out_data[DW-1]);

endmodule

// File: tb/test_burst_ramp_scaler.sv
module test_burst_ramp_scaler;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, burst_en = 1'b0, coef_we = 1'b0, interp_en = 1'b0;
  logic signed [15:0] in_data = '0;
  logic [14:0] fine_gain = 15'd16384;
  logic [5:0] coef_addr = '0;
  logic [15:0] coef_wdata = '0;
  logic [6:0] coef_count = 7'd4;
  logic out_valid;
  logic signed [15:0] out_data;

  int errors = 0, checks = 0, kx = 0;
  int ctab [64];
  logic signed [15:0] exp_q [$];
  string tag_q [$];
  bit done = 0;

  always #4 clk = ~clk;

  burst_ramp_scaler i_burst_ramp_scaler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .burst_en(burst_en), .fine_gain(fine_gain), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_wdata(coef_wdata), .coef_count(coef_count),
    .interp_en(interp_en), .out_valid(out_valid), .out_data(out_data));

  function automatic logic signed [15:0] model(int x, int g, int f);
    longint p1, p2;
    p1 = (longint'(x) * longint'(g)) >>> 14;
    p2 = (p1 * longint'(f)) >>> 16;
    if (p2 > 32767) return 16'sd32767;
    if (p2 < -32768) return -16'sd32768;
    return 16'(p2);
  endfunction

  function automatic int rampf(int s, bit ip);
    if (!ip) return ctab[s];
    if (s % 2 == 1) return (ctab[s/2] + ctab[s/2 + 1]) / 2;
    return ctab[s/2];
  endfunction

  task automatic send_x(int x, logic en, int f, string tag);
    in_data = 16'(x);
    burst_en = en;
    in_valid = 1'b1;
    exp_q.push_back(model(x, fine_gain, f));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send(logic en, int f, string tag);
    int x;
    kx++;
    x = ((kx * 3571) % 30000) - 15000;
    send_x(x, en, f, tag);
  endtask

  task automatic wr(int a, int v);
    coef_we = 1'b1;
    coef_addr = 6'(a);
    coef_wdata = 16'(v);
    ctab[a] = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk)
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check("R4 unexpected out_valid", 1, 0);
      else begin
        logic signed [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(out_data), int'(e));
      end
    end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset out_valid", int'(out_valid), 0);
    check("R4 reset out_data", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) wr(i, 1000 * (i + 1) + 7);

    // R10: idle samples give zero
    for (int i = 0; i < 3; i++) send(1'b0, 0, "R10");

    // R5 R6 R7: count 4, gap inside ramp-up
    coef_count = 7'd4;
    for (int i = 0; i < 4; i++) begin
      send(1'b1, rampf(i, 0), "R5");
      if (i == 1) repeat (3) @(negedge clk);
    end
    for (int i = 0; i < 3; i++) send(1'b1, 65535, "R6");
    for (int i = 3; i >= 0; i--) send(1'b0, rampf(i, 0), "R7");
    for (int i = 0; i < 2; i++) send(1'b0, 0, "R10");
    repeat (2) @(negedge clk);
    check("R4 idle out_valid", int'(out_valid), 0);

    // R9: interpolated, count 3 -> 5 factors
    interp_en = 1'b1;
    coef_count = 7'd3;
    for (int i = 0; i < 5; i++) send(1'b1, rampf(i, 1), "R9");
    for (int i = 0; i < 2; i++) send(1'b1, 65535, "R6");
    for (int i = 4; i >= 0; i--) send(1'b0, rampf(i, 1), "R9");
    send(1'b0, 0, "R10");
    interp_en = 1'b0;

    // R8: early close during ramp-up
    coef_count = 7'd8;
    for (int i = 0; i < 3; i++) send(1'b1, rampf(i, 0), "R8");
    for (int i = 2; i >= 0; i--) send(1'b0, rampf(i, 0), "R8");
    send(1'b0, 0, "R8");

    // R11: reopen during ramp-down
    coef_count = 7'd4;
    for (int i = 0; i < 4; i++) send(1'b1, rampf(i, 0), "R11");
    send(1'b1, 65535, "R11");
    send(1'b0, rampf(3, 0), "R11");
    for (int i = 2; i >= 0; i--) send(1'b1, rampf(i, 0), "R11");
    for (int i = 0; i < 4; i++) send(1'b1, rampf(i, 0), "R11");
    for (int i = 3; i >= 0; i--) send(1'b0, rampf(i, 0), "R11");

    // R2: count 0 acts as 1, count 100 acts as 64
    coef_count = 7'd0;
    send(1'b1, rampf(0, 0), "R2");
    send(1'b1, 65535, "R2");
    send(1'b0, rampf(0, 0), "R2");
    send(1'b0, 0, "R2");
    coef_count = 7'd100;
    for (int i = 0; i < 64; i++) send(1'b1, rampf(i, 0), "R2");
    send(1'b1, 65535, "R2");
    for (int i = 63; i >= 0; i--) send(1'b0, rampf(i, 0), "R2");

    // R1: rewrite an entry
    wr(1, 40000);
    coef_count = 7'd2;
    send(1'b1, rampf(0, 0), "R1");
    send(1'b1, 40000, "R1");
    send(1'b0, 40000, "R1");
    send(1'b0, rampf(0, 0), "R1");

    // R3 R12: gain variations and saturation at full power
    send(1'b1, rampf(0, 0), "R3");
    send(1'b1, 40000, "R3");
    fine_gain = 15'h1234;
    send_x(-12345, 1'b1, 65535, "R3");
    send_x(23456, 1'b1, 65535, "R3");
    fine_gain = 15'h7FFF;
    send_x(32767, 1'b1, 65535, "R12");
    send_x(-32768, 1'b1, 65535, "R12");
    send_x(1, 1'b1, 65535, "R12");
    fine_gain = 15'd0;
    send_x(30000, 1'b1, 65535, "R3");
    fine_gain = 15'd16384;
    send(1'b0, 40000, "R3");
    send(1'b0, rampf(0, 0), "R3");

    repeat (4) @(negedge clk);
    check("R4 queue drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule